// File: doc/BRIEF.md
# Effective Address Generator for Data Moves

This block turns a decoded addressing mode and its operands into the memory address of a data move. It receives a base register value, an index register value, a second address register value, the stack pointer and an immediate field. Plain modes (base register alone, or an absolute immediate) produce their address one clock after the request is taken. Modes that need an addition or subtraction hold the request for one extra clock and raise a stall output for exactly that clock. Transfers between two registers are also accepted, but they produce no memory access.

The operand-size tag travels with the address unchanged so that the memory side knows the access width and sign treatment. A new request is taken whenever the block is not in its extra calculation clock. This includes the clock in which the previous address is being issued, so plain moves can follow each other every clock. Memory is assumed to answer with no wait states.

Top module: `eff_addr_unit`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears `addr_valid`, `stall`, `move_done`, `addr_out` and `addr_size` to zero, drives `req_ready` high, and abandons any calculation in progress.
- R2: Mode code 1 (base register) and mode code 2 (absolute, address = full immediate) raise `addr_valid` with the address on the clock after acceptance, with no stall, for every size tag.
- R3: Mode code 3 (base + index register) and mode code 4 (base + second address register) raise `stall` on the clock after acceptance, then present the sum with `addr_valid` on the clock after that.
- R4: Mode code 5 adds the low SHORT_W bits of the immediate, sign-extended, to the base; the immediate bits above SHORT_W have no effect on the address. It takes the extra clock.
- R5: Mode code 6 adds the full-width immediate to the base, modulo 2^AW. It takes the extra clock.
- R6: Mode code 7 subtracts the low SHORT_W bits of the immediate, taken as unsigned, from the stack pointer. Mode code 8 adds the full-width immediate to the stack pointer. Both take the extra clock.
- R7: `stall` is high for exactly one clock per calculated access, `addr_valid` is low during that clock, and `addr_valid` rises on the next clock.
- R8: Mode code 0 (register to register) and the unused codes 9 to 15 never raise `addr_valid`; each pulses `move_done` for one clock after acceptance.
- R9: `addr_size` equals the 4-bit size tag of the accepted request from the clock after acceptance (tag bit 3 = signed, bits 2:0 = width code), and holds through the stall clock.
- R10: `req_ready` is low only during the stall clock. A request held through that clock is taken on the next edge, and a request offered while an address is being issued is taken in that same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is taken at this edge when high |
| req_mode | input | 4 | Addressing mode code |
| req_size | input | 4 | Operand size tag: bit 3 signed, bits 2:0 width code |
| req_base | input | AW | Base address register value |
| req_index | input | AW | Index register value |
| req_reg | input | AW | Second address register value |
| req_sp | input | AW | Stack pointer value |
| req_imm | input | AW | Immediate field (short forms use low SHORT_W bits) |
| addr_valid | output | 1 | Address is valid this clock |
| addr_out | output | AW | Effective address |
| addr_size | output | 4 | Size tag of the issued access |
| stall | output | 1 | Extra address-calculation clock in progress |
| move_done | output | 1 | A move with no memory access was taken |

## Verification
Two functions can fall in the same clock: the issue of one address and the acceptance of the next request. The bench holds `req_valid` high with new operands across the edge where an address is out. It then checks that the following clock carries the new address with no gap. The second pairing is a request offered during the stall clock. The bench keeps that request held and checks that `req_ready` is low and that the calculated address comes out first. The held request's address must follow one clock later, with no loss and no duplication.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [3:0] {
      AM_REGMOVE = 4'd0,
      AM_BASE    = 4'd1,
      AM_ABS     = 4'd2,
      AM_IDX     = 4'd3,
      AM_RREG    = 4'd4,
      AM_DSHORT  = 4'd5,
      AM_DLONG   = 4'd6,
      AM_SPMINUS = 4'd7,
      AM_SPPLUS  = 4'd8
   } am_code_e;

   typedef enum logic [1:0] {
      SEL_A_BASE = 2'd0,
      SEL_A_SP   = 2'd1,
      SEL_A_IMM  = 2'd2
   } sel_a_e;

   typedef enum logic [2:0] {
      SEL_B_IDX  = 3'd0,
      SEL_B_REG  = 3'd1,
      SEL_B_SSX  = 3'd2,
      SEL_B_SZX  = 3'd3,
      SEL_B_LONG = 3'd4
   } sel_b_e;

   typedef struct packed {
      logic   mem;
      logic   calc;
      logic   sub;
      sel_a_e a_sel;
      sel_b_e b_sel;
   } am_dec_t;

   localparam int unsigned TAG_W = 4;

endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
   import agu_pkg::*;
(
   input  logic [3:0] mode,
   output am_dec_t    dec
);

   always_comb begin
      dec = '{mem: 1'b0, calc: 1'b0, sub: 1'b0, a_sel: SEL_A_BASE, b_sel: SEL_B_IDX};
      case (mode)
         AM_BASE:    dec = '{mem: 1'b1, calc: 1'b0, sub: 1'b0, a_sel: SEL_A_BASE, b_sel: SEL_B_IDX};
         AM_ABS:     dec = '{mem: 1'b1, calc: 1'b0, sub: 1'b0, a_sel: SEL_A_IMM,  b_sel: SEL_B_IDX};
         AM_IDX:     dec = '{mem: 1'b1, calc: 1'b1, sub: 1'b0, a_sel: SEL_A_BASE, b_sel: SEL_B_IDX};
         AM_RREG:    dec = '{mem: 1'b1, calc: 1'b1, sub: 1'b0, a_sel: SEL_A_BASE, b_sel: SEL_B_REG};
         AM_DSHORT:  dec = '{mem: 1'b1, calc: 1'b1, sub: 1'b0, a_sel: SEL_A_BASE, b_sel: SEL_B_SSX};
         AM_DLONG:   dec = '{mem: 1'b1, calc: 1'b1, sub: 1'b0, a_sel: SEL_A_BASE, b_sel: SEL_B_LONG};
         AM_SPMINUS: dec = '{mem: 1'b1, calc: 1'b1, sub: 1'b1, a_sel: SEL_A_SP,   b_sel: SEL_B_SZX};
         AM_SPPLUS:  dec = '{mem: 1'b1, calc: 1'b1, sub: 1'b0, a_sel: SEL_A_SP,   b_sel: SEL_B_LONG};
         default:    dec = '{mem: 1'b0, calc: 1'b0, sub: 1'b0, a_sel: SEL_A_BASE, b_sel: SEL_B_IDX};
      endcase
   end

endmodule

// File: rtl/agu_operand_sel.sv
module agu_operand_sel
   import agu_pkg::*;
#(
   parameter int unsigned AW      = 32,
   parameter int unsigned SHORT_W = 16
) (
   input  am_dec_t        dec,
   input  logic [AW-1:0]  base,
   input  logic [AW-1:0]  index,
   input  logic [AW-1:0]  rreg,
   input  logic [AW-1:0]  sp,
   input  logic [AW-1:0]  imm,
   output logic [AW-1:0]  opa,
   output logic [AW-1:0]  opb,
   output logic [AW-1:0]  plain_addr
);

   localparam int unsigned EXT_W = AW - SHORT_W;

   logic [AW-1:0] short_sx;
   logic [AW-1:0] short_zx;

   assign short_sx = {{EXT_W{imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
   assign short_zx = {{EXT_W{1'b0}}, imm[SHORT_W-1:0]};

   assign opa        = (dec.a_sel == SEL_A_SP) ? sp : base;
   assign plain_addr = (dec.a_sel == SEL_A_IMM) ? imm : base;

   always_comb begin
      case (dec.b_sel)
         SEL_B_IDX:  opb = index;
         SEL_B_REG:  opb = rreg;
         SEL_B_SSX:  opb = short_sx;
         SEL_B_SZX:  opb = short_zx;
         default:    opb = imm;
      endcase
   end

endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
   parameter int unsigned AW    = 32,
   parameter bit          SPLIT = 1'b0
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   input  logic          sub,
   output logic [AW-1:0] sum
);

   logic [AW-1:0] b_eff;
   assign b_eff = sub ? ~b : b;

   generate
      if (SPLIT == 1'b0) begin : g_flat
         assign sum = a + b_eff + {{(AW-1){1'b0}}, sub};
      end else begin : g_csel
         localparam int unsigned LO_W = AW / 2;
         localparam int unsigned HI_W = AW - LO_W;
         logic [LO_W:0]   lo_s;
         logic [HI_W-1:0] hi_0;
         logic [HI_W-1:0] hi_1;
         assign lo_s = {1'b0, a[LO_W-1:0]} + {1'b0, b_eff[LO_W-1:0]}
                     + {{LO_W{1'b0}}, sub};
         assign hi_0 = a[AW-1:LO_W] + b_eff[AW-1:LO_W];
         assign hi_1 = hi_0 + {{(HI_W-1){1'b0}}, 1'b1};
         assign sum  = {(lo_s[LO_W] ? hi_1 : hi_0), lo_s[LO_W-1:0]};
      end
   endgenerate

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
   import agu_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned SHORT_W   = 16,
   parameter bit          ADD_SPLIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [3:0]        req_mode,
   input  logic [TAG_W-1:0]  req_size,
   input  logic [AW-1:0]     req_base,
   input  logic [AW-1:0]     req_index,
   input  logic [AW-1:0]     req_reg,
   input  logic [AW-1:0]     req_sp,
   input  logic [AW-1:0]     req_imm,
   output logic              addr_valid,
   output logic [AW-1:0]     addr_out,
   output logic [TAG_W-1:0]  addr_size,
   output logic              stall,
   output logic              move_done
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("eff_addr_unit: AW must be at least 8");
      end
      if (SHORT_W < 2 || SHORT_W >= AW) begin : g_bad_short
         $error("eff_addr_unit: SHORT_W must lie in 2..AW-1");
      end
   endgenerate

   am_dec_t       dec;
   logic [AW-1:0] opa, opb, plain_addr, sum;
   logic [AW-1:0] opa_q, opb_q;
   logic          sub_q;
   logic          stall_q, valid_q, done_q;
   logic [AW-1:0] addr_q;
   logic [TAG_W-1:0] size_q;

   agu_mode_decode u_dec (
      .mode (req_mode),
      .dec  (dec)
   );

   agu_operand_sel #(.AW(AW), .SHORT_W(SHORT_W)) u_opsel (
      .dec        (dec),
      .base       (req_base),
      .index      (req_index),
      .rreg       (req_reg),
      .sp         (req_sp),
      .imm        (req_imm),
      .opa        (opa),
      .opb        (opb),
      .plain_addr (plain_addr)
   );

   agu_adder #(.AW(AW), .SPLIT(ADD_SPLIT)) u_add (
      .a   (opa_q),
      .b   (opb_q),
      .sub (sub_q),
      .sum (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
         addr_q  <= '0;
         size_q  <= '0;
         opa_q   <= '0;
         opb_q   <= '0;
         sub_q   <= 1'b0;
      end else begin
         stall_q <= 1'b0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
         if (stall_q) begin
            addr_q  <= sum;
            valid_q <= 1'b1;
         end else if (req_valid) begin
            size_q <= req_size;
            if (!dec.mem) begin
               done_q <= 1'b1;
            end else if (dec.calc) begin
               stall_q <= 1'b1;
               opa_q   <= opa;
               opb_q   <= opb;
               sub_q   <= dec.sub;
            end else begin
               addr_q  <= plain_addr;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign req_ready  = ~stall_q;
   assign stall      = stall_q;
   assign addr_valid = valid_q;
   assign addr_out   = addr_q;
   assign addr_size  = size_q;
   assign move_done  = done_q;

endmodule

// File: rtl/eff_addr_unit_checker.sv
module eff_addr_unit_checker
   import agu_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [3:0] req_mode,
   input logic [3:0] req_size,
   input logic       addr_valid,
   input logic [3:0] addr_size,
   input logic       stall,
   input logic       move_done
);

   logic take, calc_mode, plain_mode;
   assign take       = req_valid && req_ready;
   assign calc_mode  = (req_mode >= AM_IDX) && (req_mode <= AM_SPPLUS);
   assign plain_mode = (req_mode == AM_BASE) || (req_mode == AM_ABS);

   a_r7_stall_one: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);
   a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> addr_valid);
   a_r7_quiet_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !addr_valid);
   a_r3_calc_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (take && calc_mode) |=> (stall && !move_done));
   a_r2_plain_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (take && plain_mode) |=> (addr_valid && !stall));
   a_r8_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !calc_mode && !plain_mode) |=> (move_done && !addr_valid && !stall));
   a_r9_size_tag: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (addr_size == $past(req_size)));
   a_r9_size_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(addr_size));

endmodule

bind eff_addr_unit eff_addr_unit_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_mode   (req_mode),
   .req_size   (req_size),
   .addr_valid (addr_valid),
   .addr_size  (addr_size),
   .stall      (stall),
   .move_done  (move_done)
);

// File: tb/eff_addr_unit_test.sv
module eff_addr_unit_test;

   localparam int CLK_P = 10;
   localparam logic [31:0] IDX = 32'h0000_0040;
   localparam logic [31:0] RRG = 32'h0000_0100;
   localparam logic [31:0] SPV = 32'h0020_0000;
   localparam logic [31:0] BSV = 32'h1000_0000;

   typedef struct packed {
      logic [3:0]  mode;
      logic [3:0]  size;
      logic [31:0] base;
      logic [31:0] imm;
      logic [31:0] exp;
      logic        calc;
      logic        mem;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{4'd0, 4'h3, BSV,          32'h0,         32'h0,         1'b0, 1'b0},
      '{4'd1, 4'h0, BSV,          32'h0,         32'h1000_0000, 1'b0, 1'b1},
      '{4'd2, 4'h9, BSV,          32'h0000_ABCD, 32'h0000_ABCD, 1'b0, 1'b1},
      '{4'd3, 4'h1, BSV,          32'h0,         32'h1000_0040, 1'b1, 1'b1},
      '{4'd4, 4'h2, BSV,          32'h0,         32'h1000_0100, 1'b1, 1'b1},
      '{4'd5, 4'hB, BSV,          32'h0000_FFF0, 32'h0FFF_FFF0, 1'b1, 1'b1},
      '{4'd5, 4'h3, BSV,          32'h0000_0010, 32'h1000_0010, 1'b1, 1'b1},
      '{4'd6, 4'h4, BSV,          32'h8000_0000, 32'h9000_0000, 1'b1, 1'b1},
      '{4'd7, 4'hD, BSV,          32'h0000_8000, 32'h001F_8000, 1'b1, 1'b1},
      '{4'd8, 4'h5, BSV,          32'hFFFF_FFF0, 32'h001F_FFF0, 1'b1, 1'b1},
      '{4'd9, 4'h1, BSV,          32'h0,         32'h0,         1'b0, 1'b0},
      '{4'd5, 4'hC, BSV,          32'hABCD_0004, 32'h1000_0004, 1'b1, 1'b1},
      '{4'd6, 4'h2, 32'h1000_0000, 32'hF000_0000, 32'h0000_0000, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_mode = '0;
   logic [3:0]  req_size = '0;
   logic [31:0] req_base = '0;
   logic [31:0] req_index = IDX;
   logic [31:0] req_reg = RRG;
   logic [31:0] req_sp = SPV;
   logic [31:0] req_imm = '0;
   logic        addr_valid;
   logic [31:0] addr_out;
   logic [3:0]  addr_size;
   logic        stall;
   logic        move_done;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   eff_addr_unit uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_mode   (req_mode),
      .req_size   (req_size),
      .req_base   (req_base),
      .req_index  (req_index),
      .req_reg    (req_reg),
      .req_sp     (req_sp),
      .req_imm    (req_imm),
      .addr_valid (addr_valid),
      .addr_out   (addr_out),
      .addr_size  (addr_size),
      .stall      (stall),
      .move_done  (move_done)
   );

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] m);
      case (m)
         4'd1, 4'd2: return "R2";
         4'd3, 4'd4: return "R3";
         4'd5:       return "R4";
         4'd6:       return "R5";
         4'd7, 4'd8: return "R6";
         default:    return "R8";
      endcase
   endfunction

   task automatic drive(input logic [3:0] m, input logic [3:0] s,
                        input logic [31:0] b, input logic [31:0] im);
      req_mode = m; req_size = s; req_base = b; req_imm = im; req_valid = 1'b1;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 5000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state held in reset
      check("R1 valid in reset", {31'b0, addr_valid}, 32'd0);
      check("R1 stall in reset", {31'b0, stall}, 32'd0);
      check("R1 ready in reset", {31'b0, req_ready}, 32'd1);
      check("R1 addr in reset", addr_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R2..R6, R7, R8, R9
      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].mode, TBL[i].size, TBL[i].base, TBL[i].imm);
         @(posedge clk);
         #1 req_valid = 1'b0;
         @(negedge clk);
         if (!TBL[i].mem) begin
            check({tag_of(TBL[i].mode), " move_done"}, {31'b0, move_done}, 32'd1);
            check({tag_of(TBL[i].mode), " no access"}, {31'b0, addr_valid}, 32'd0);
         end else if (!TBL[i].calc) begin
            check({tag_of(TBL[i].mode), " valid"}, {31'b0, addr_valid}, 32'd1);
            check({tag_of(TBL[i].mode), " no stall"}, {31'b0, stall}, 32'd0);
            check({tag_of(TBL[i].mode), " addr"}, addr_out, TBL[i].exp);
            check("R9 size tag", {28'b0, addr_size}, {28'b0, TBL[i].size});
         end else begin
            check("R7 stall high", {31'b0, stall}, 32'd1);
            check("R7 valid low in stall", {31'b0, addr_valid}, 32'd0);
            check("R10 ready low in stall", {31'b0, req_ready}, 32'd0);
            @(negedge clk);
            check("R7 stall one clock", {31'b0, stall}, 32'd0);
            check("R7 valid after stall", {31'b0, addr_valid}, 32'd1);
            check({tag_of(TBL[i].mode), " addr"}, addr_out, TBL[i].exp);
            check("R9 size tag", {28'b0, addr_size}, {28'b0, TBL[i].size});
         end
      end

      // R10: request held during the stall clock is taken afterwards
      drive(4'd3, 4'h6, 32'h0000_5000, 32'h0);
      @(posedge clk);
      #1 drive(4'd2, 4'h7, 32'h0, 32'h0000_1234);
      @(negedge clk);
      check("R10 ready low while held", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      check("R10 first addr issued", addr_out, 32'h0000_5040);
      check("R10 ready back", {31'b0, req_ready}, 32'd1);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      check("R10 held request addr", addr_out, 32'h0000_1234);
      check("R10 held request valid", {31'b0, addr_valid}, 32'd1);
      check("R9 held request size", {28'b0, addr_size}, 32'd7);

      // R10: back-to-back plain moves
      drive(4'd1, 4'h0, 32'h0000_2000, 32'h0);
      @(posedge clk);
      #1 drive(4'd2, 4'h0, 32'h0, 32'h0000_3000);
      @(negedge clk);
      check("R10 first of pair", addr_out, 32'h0000_2000);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      check("R10 second of pair", addr_out, 32'h0000_3000);
      check("R10 second valid", {31'b0, addr_valid}, 32'd1);
      @(negedge clk);
      check("R10 idle valid low", {31'b0, addr_valid}, 32'd0);

      // R1: reset during the stall clock
      drive(4'd4, 4'h2, 32'h0000_7000, 32'h0);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 stall cleared", {31'b0, stall}, 32'd0);
      check("R1 ready after reset", {31'b0, req_ready}, 32'd1);
      check("R1 size cleared", {28'b0, addr_size}, 32'd0);
      @(negedge clk);
      check("R1 no late address", {31'b0, addr_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule